// File: doc/BRIEF.md
# Audio Master Clock Divider Chain

This block turns a master audio clock into the serial bit clock and the left/right word clock of a serial audio port that acts as clock master. Two divider stages are chained: the master clock is divided by 2 or 4 to form the bit clock, and the bit clock is divided by 32, 64 or 128 to form one word-clock period (one stereo frame). The word clock is low for the left half of the frame and high for the right half, before any polarity inversion. Both clocks are generated from registers clocked by the master clock, so each output edge lines up with a master-clock edge.

A serializer next to the block uses two single-cycle strobes. A launch strobe comes one master-clock cycle before each bit-clock edge on which data changes. A frame strobe comes with the launch strobe for the first bit of the left slot. Configuration inputs choose the ratios, invert either clock, and decide whether the bit clock runs all the time or only while transmit or receive is enabled. A ratio written while the clocks run is held in a shadow register and takes effect only at the next frame boundary, so no shortened bit or half-frame is produced. In slave mode the pin enables stay off and no clock or strobe is generated.

Top module: `audclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, bclk_o and wclk_o are at their idle levels, launch_o and frame_o are low, and both pin enables are low.
- R2: When master_mode is 0, bclk_oe and wclk_oe are low, no launch or frame strobe is issued, and the clocks stay at their idle levels.
- R3: One bit-clock period lasts 2 master-clock cycles when bclk_div_sel is 0 and 4 cycles when it is 1. The bit clock is low (before inversion) for the first half of each period and high for the second half.
- R4: frame_sel sets the bit clocks per word-clock period: code 00 gives 32, 01 gives 64, and 10 or 11 give 128. Before inversion the word clock is low for the first half of the frame (left slot) and high for the second half, and it changes together with the bit clock's falling edge.
- R5: launch_o is high for exactly one cycle per bit, in the cycle just before the uninverted bit clock falls, so a frame of F bits carries F launch strobes.
- R6: frame_o is high exactly once per frame, only together with launch_o, for the launch that starts bit 0 of the left slot.
- R7: bclk_inv inverts bclk_o and wclk_inv inverts wclk_o. The idle level of each clock output equals its inversion bit.
- R8: With free_run at 0, both clocks stop at idle and no strobes are issued while tx_en and rx_en are both low. Setting free_run to 1 runs the clocks whatever the enables are.
- R9: With glb_en at 0, both clocks sit at their idle levels and no strobes are issued. Setting glb_en again restarts the chain at a frame boundary.
- R10: A change of bclk_div_sel or frame_sel made while the clocks run leaves the frame in progress at its old length and timing. The new ratios apply from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: this block drives the clocks; 0: it leaves them to the external device |
| glb_en | input | 1 | Global run enable for the port |
| tx_en | input | 1 | Transmit path enable |
| rx_en | input | 1 | Receive path enable |
| free_run | input | 1 | 1: the clocks run even with both path enables low |
| bclk_div_sel | input | 1 | Master-to-bit-clock ratio: 0 gives 2, 1 gives 4 |
| frame_sel | input | 2 | Bit clocks per frame: 00 gives 32, 01 gives 64, 10 and 11 give 128 |
| bclk_inv | input | 1 | Inverts the driven bit clock |
| wclk_inv | input | 1 | Inverts the driven word clock |
| bclk_o | output | 1 | Bit clock to the pin |
| wclk_o | output | 1 | Word clock to the pin |
| bclk_oe | output | 1 | Output enable for the bit-clock pin |
| wclk_oe | output | 1 | Output enable for the word-clock pin |
| launch_o | output | 1 | One-cycle strobe before each data-launch edge of the bit clock |
| frame_o | output | 1 | One-cycle strobe with the launch of the first left-slot bit |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of a running frame. The bench has to put the write strictly between two frame strobes and then show that the frame in progress keeps its old length. To do this the driver locks onto a frame strobe and queues an expectation with the old ratio, which the monitor measures over the next full frame. The driver then waits for the strobe that opens that frame, waits a few more cycles, and writes the new ratios. A second expectation, with the new ratios, then confirms that the switch happens at the following boundary.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    // Ratio selection held in the shadow stage
    typedef struct packed {
        logic       div_hi;     // 0: master/2, 1: master/4
        logic [1:0] frame_sel;  // 00: 32, 01: 64, 1x: 128 bit clocks per frame
    } ratio_t;

    localparam ratio_t RATIO_RST = '{div_hi: 1'b0, frame_sel: 2'b00};

    // Number of frame-length codes
    localparam int FRAME_CODES = 4;

endpackage

// File: rtl/audclk_shadow.sv
module audclk_shadow
    import audclk_pkg::*;
#(
    parameter int DIV_LO     = 2,
    parameter int DIV_HI     = 4,
    parameter int FRAME_BASE = 32,
    parameter int PH_W       = 3,
    parameter int BIT_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             div_hi,
    input  logic [1:0]       frame_sel,
    output logic [PH_W-1:0]  ph_last,
    output logic [PH_W-1:0]  ph_half,
    output logic [BIT_W-1:0] bit_last,
    output logic [BIT_W-1:0] bit_half
);

    ratio_t r_d, r_q;

    logic [BIT_W-1:0] last_tbl [FRAME_CODES];
    logic [BIT_W-1:0] half_tbl [FRAME_CODES];

    // Frame-length table: base length doubled per code, saturating at four times
    for (genvar g = 0; g < FRAME_CODES; g++) begin : g_frame
        localparam int SHIFT = (g > 2) ? 2 : g;
        localparam int LEN   = FRAME_BASE << SHIFT;
        assign last_tbl[g] = BIT_W'(LEN - 1);
        assign half_tbl[g] = BIT_W'(LEN / 2);
    end

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.div_hi    = div_hi;
            r_d.frame_sel = frame_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RATIO_RST;
        else        r_q <= r_d;
    end

    assign ph_last  = r_q.div_hi ? PH_W'(DIV_HI - 1) : PH_W'(DIV_LO - 1);
    assign ph_half  = r_q.div_hi ? PH_W'(DIV_HI / 2) : PH_W'(DIV_LO / 2);
    assign bit_last = last_tbl[r_q.frame_sel];
    assign bit_half = half_tbl[r_q.frame_sel];

endmodule

// File: rtl/audclk_seq.sv
module audclk_seq #(
    parameter int PH_W  = 3,
    parameter int BIT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_mode,
    input  logic             glb_en,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             free_run,
    input  logic [PH_W-1:0]  ph_last,
    input  logic [PH_W-1:0]  ph_half,
    input  logic [BIT_W-1:0] bit_last,
    input  logic [BIT_W-1:0] bit_half,
    output logic             shadow_load,
    output logic             bclk_raw,
    output logic             wclk_raw,
    output logic             launch,
    output logic             frame,
    output logic             pins_oe
);

    typedef struct packed {
        logic             run;
        logic [PH_W-1:0]  ph;
        logic [BIT_W-1:0] bitc;
        logic             bclk;
        logic             wclk;
        logic             launch;
        logic             frame;
        logic             oe;
    } seq_t;

    seq_t s_d, s_q;
    logic run_req;
    logic wrap;

    always_comb begin
        run_req     = master_mode && glb_en && (free_run || tx_en || rx_en);
        wrap        = s_q.run && run_req && (s_q.ph == ph_last) && (s_q.bitc == bit_last);
        // ratios follow the inputs only while idle, and otherwise only at a frame wrap
        shadow_load = wrap || (!s_q.run && !run_req);

        s_d     = '0;
        s_d.oe  = master_mode;
        s_d.run = run_req;

        if (run_req && !s_q.run) begin
            // pre-start cycle: park on the last phase of the last bit, clocks still idle
            s_d.ph     = ph_last;
            s_d.bitc   = bit_last;
            s_d.launch = 1'b1;
            s_d.frame  = 1'b1;
        end else if (run_req) begin
            if (s_q.ph == ph_last) begin
                s_d.ph   = '0;
                s_d.bitc = (s_q.bitc == bit_last) ? '0 : s_q.bitc + BIT_W'(1);
            end else begin
                s_d.ph   = s_q.ph + PH_W'(1);
                s_d.bitc = s_q.bitc;
            end
            s_d.bclk   = (s_d.ph >= ph_half);
            s_d.wclk   = (s_d.bitc >= bit_half);
            s_d.launch = (s_d.ph == ph_last);
            s_d.frame  = s_d.launch && (s_d.bitc == bit_last);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bclk_raw = s_q.bclk;
    assign wclk_raw = s_q.wclk;
    assign launch   = s_q.launch;
    assign frame    = s_q.frame;
    assign pins_oe  = s_q.oe;

endmodule

// File: rtl/audclk_outpol.sv
module audclk_outpol #(
    parameter int NCLK = 2
) (
    input  logic [NCLK-1:0] raw,
    input  logic [NCLK-1:0] inv,
    output logic [NCLK-1:0] pin
);

    for (genvar g = 0; g < NCLK; g++) begin : g_pol
        assign pin[g] = raw[g] ^ inv[g];
    end

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen #(
    parameter int DIV_LO     = 2,
    parameter int DIV_HI     = 4,
    parameter int FRAME_BASE = 32
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       master_mode,
    input  logic       glb_en,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       free_run,
    input  logic       bclk_div_sel,
    input  logic [1:0] frame_sel,
    input  logic       bclk_inv,
    input  logic       wclk_inv,
    output logic       bclk_o,
    output logic       wclk_o,
    output logic       bclk_oe,
    output logic       wclk_oe,
    output logic       launch_o,
    output logic       frame_o
);

    localparam int PH_W  = $clog2(DIV_HI + 1);
    localparam int BIT_W = $clog2(FRAME_BASE * 4);

    logic [PH_W-1:0]  ph_last, ph_half;
    logic [BIT_W-1:0] bit_last, bit_half;
    logic             shadow_load;
    logic             bclk_raw, wclk_raw, pins_oe;
    logic [1:0]       pol_pin;

    audclk_shadow #(
        .DIV_LO     (DIV_LO),
        .DIV_HI     (DIV_HI),
        .FRAME_BASE (FRAME_BASE),
        .PH_W       (PH_W),
        .BIT_W      (BIT_W)
    ) u_shadow (
        .clk       (mclk),
        .rst_n     (rst_n),
        .load      (shadow_load),
        .div_hi    (bclk_div_sel),
        .frame_sel (frame_sel),
        .ph_last   (ph_last),
        .ph_half   (ph_half),
        .bit_last  (bit_last),
        .bit_half  (bit_half)
    );

    audclk_seq #(
        .PH_W  (PH_W),
        .BIT_W (BIT_W)
    ) u_seq (
        .clk         (mclk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .glb_en      (glb_en),
        .tx_en       (tx_en),
        .rx_en       (rx_en),
        .free_run    (free_run),
        .ph_last     (ph_last),
        .ph_half     (ph_half),
        .bit_last    (bit_last),
        .bit_half    (bit_half),
        .shadow_load (shadow_load),
        .bclk_raw    (bclk_raw),
        .wclk_raw    (wclk_raw),
        .launch      (launch_o),
        .frame       (frame_o),
        .pins_oe     (pins_oe)
    );

    audclk_outpol #(
        .NCLK (2)
    ) u_pol (
        .raw ({wclk_raw, bclk_raw}),
        .inv ({wclk_inv, bclk_inv}),
        .pin (pol_pin)
    );

    assign bclk_o  = pol_pin[0];
    assign wclk_o  = pol_pin[1];
    assign bclk_oe = pins_oe;
    assign wclk_oe = pins_oe;

endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk (
    input logic mclk,
    input logic rst_n,
    input logic master_mode,
    input logic glb_en,
    input logic tx_en,
    input logic rx_en,
    input logic free_run,
    input logic bclk_inv,
    input logic wclk_inv,
    input logic bclk_o,
    input logic wclk_o,
    input logic bclk_oe,
    input logic wclk_oe,
    input logic launch_o,
    input logic frame_o
);

    // R2
    slave_quiet_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        !master_mode |=> (!bclk_oe && !wclk_oe && !launch_o && !frame_o));

    // R9
    global_off_idle_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        !glb_en |=> (bclk_o == bclk_inv && wclk_o == wclk_inv && !launch_o));

    // R8
    gated_idle_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (!free_run && !tx_en && !rx_en) |=> (!launch_o && bclk_o == bclk_inv));

    // R6
    frame_with_launch_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        frame_o |-> launch_o);

    // R5
    launch_then_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        launch_o |=> (bclk_o == bclk_inv));

endmodule

bind audclk_gen audclk_gen_chk u_chk (
    .mclk        (mclk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .glb_en      (glb_en),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .free_run    (free_run),
    .bclk_inv    (bclk_inv),
    .wclk_inv    (wclk_inv),
    .bclk_o      (bclk_o),
    .wclk_o      (wclk_o),
    .bclk_oe     (bclk_oe),
    .wclk_oe     (wclk_oe),
    .launch_o    (launch_o),
    .frame_o     (frame_o)
);

// File: tb/audclk_gen_test.sv
module audclk_gen_test;

    localparam int CLK_PER = 10;

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_mode = 1'b1;
    logic       glb_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       free_run = 1'b0;
    logic       bclk_div_sel = 1'b0;
    logic [1:0] frame_sel = 2'b00;
    logic       bclk_inv = 1'b0;
    logic       wclk_inv = 1'b0;
    logic       bclk_o, wclk_o, bclk_oe, wclk_oe, launch_o, frame_o;

    audclk_gen uut (
        .mclk         (mclk),
        .rst_n        (rst_n),
        .master_mode  (master_mode),
        .glb_en       (glb_en),
        .tx_en        (tx_en),
        .rx_en        (rx_en),
        .free_run     (free_run),
        .bclk_div_sel (bclk_div_sel),
        .frame_sel    (frame_sel),
        .bclk_inv     (bclk_inv),
        .wclk_inv     (wclk_inv),
        .bclk_o       (bclk_o),
        .wclk_o       (wclk_o),
        .bclk_oe      (bclk_oe),
        .wclk_oe      (wclk_oe),
        .launch_o     (launch_o),
        .frame_o      (frame_o)
    );

    always #(CLK_PER/2) mclk = ~mclk;

    typedef struct {
        int    d;
        int    f;
        logic  binv;
        logic  winv;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   pending = 0;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge mclk);
        #1;
    endtask

    task automatic wait_frames(input int n);
        repeat (n) begin
            do begin
                @(negedge mclk);
            end while (!frame_o);
        end
    endtask

    task automatic push_exp(input int d, input int f, input string tag);
        exp_t e;
        e.d = d; e.f = f; e.binv = bclk_inv; e.winv = wclk_inv; e.tag = tag;
        sb.push_back(e);
        pending++;
    endtask

    task automatic wait_sb();
        while (pending != 0) @(negedge mclk);
    endtask

    task automatic set_cfg(input logic dsel, input logic [1:0] fsel, input logic bi, input logic wi);
        tick(1);
        bclk_div_sel = dsel;
        frame_sel    = fsel;
        bclk_inv     = bi;
        wclk_inv     = wi;
    endtask

    // Monitor: measures one full frame per queued expectation
    int   m_cyc, m_launch, m_frame, m_bhi, m_whi;
    exp_t m_e;
    initial begin
        forever begin
            @(negedge mclk);
            if (sb.size() != 0) begin
                m_e = sb[0];
                do begin
                    @(negedge mclk);
                end while (!frame_o);
                m_cyc = 0; m_launch = 0; m_frame = 0; m_bhi = 0; m_whi = 0;
                do begin
                    @(negedge mclk);
                    m_cyc++;
                    if (launch_o) m_launch++;
                    if (frame_o) m_frame++;
                    if (bclk_o != m_e.binv) m_bhi++;
                    if (wclk_o != m_e.winv) m_whi++;
                end while (!frame_o);
                check(m_cyc == m_e.d * m_e.f, {"R4 frame period, ", m_e.tag}, m_cyc, m_e.d * m_e.f);
                check(m_launch == m_e.f, {"R5 launches per frame, ", m_e.tag}, m_launch, m_e.f);
                check(m_frame == 1, {"R6 frame strobes per frame, ", m_e.tag}, m_frame, 1);
                check(m_bhi == m_e.f * m_e.d / 2, {"R3 bit clock high cycles, ", m_e.tag}, m_bhi, m_e.f * m_e.d / 2);
                check(m_whi == m_e.f * m_e.d / 2, {"R4 word clock high cycles, ", m_e.tag}, m_whi, m_e.f * m_e.d / 2);
                check(launch_o == 1'b1, {"R6 frame strobe with launch, ", m_e.tag}, int'(launch_o), 1);
                check(bclk_o == !m_e.binv, {"R7 bit clock level at launch, ", m_e.tag}, int'(bclk_o), int'(!m_e.binv));
                check(wclk_o == !m_e.winv, {"R7 word clock right slot level, ", m_e.tag}, int'(wclk_o), int'(!m_e.winv));
                @(negedge mclk);
                check(bclk_o == m_e.binv, {"R5 bit clock falls after launch, ", m_e.tag}, int'(bclk_o), int'(m_e.binv));
                check(wclk_o == m_e.winv, {"R4 left slot starts low, ", m_e.tag}, int'(wclk_o), int'(m_e.winv));
                void'(sb.pop_front());
                pending--;
            end
        end
    end

    // Watchdog
    always @(posedge mclk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 flow actual=%0d expected=%0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    int n_launch, n_bhi, n_oe, n_whi;

    initial begin
        // R1: reset state, with master mode already requested
        repeat (3) @(negedge mclk);
        check(bclk_o == 1'b0 && wclk_o == 1'b0, "R1 clocks idle in reset", int'({bclk_o, wclk_o}), 0);
        check(!launch_o && !frame_o, "R1 strobes low in reset", int'({launch_o, frame_o}), 0);
        check(!bclk_oe && !wclk_oe, "R1 enables low in reset", int'({bclk_oe, wclk_oe}), 0);
        tick(1);
        rst_n = 1'b1;
        @(negedge mclk);
        check(bclk_o == 1'b0 && !launch_o, "R1 idle just after reset", int'({bclk_o, launch_o}), 0);

        // R2: slave mode
        master_mode = 1'b0; glb_en = 1'b1; tx_en = 1'b1; free_run = 1'b1;
        tick(2);
        n_launch = 0; n_bhi = 0; n_oe = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge mclk);
            if (launch_o || frame_o) n_launch++;
            if (bclk_o || wclk_o) n_bhi++;
            if (bclk_oe || wclk_oe) n_oe++;
        end
        check(n_oe == 0, "R2 slave enables off", n_oe, 0);
        check(n_launch == 0, "R2 slave no strobes", n_launch, 0);
        check(n_bhi == 0, "R2 slave clocks idle", n_bhi, 0);

        // R8: gated, no enables
        tick(1);
        master_mode = 1'b1; free_run = 1'b0; tx_en = 1'b0; rx_en = 1'b0;
        tick(2);
        check(bclk_oe && wclk_oe, "R2 master enables on", int'({bclk_oe, wclk_oe}), 3);
        n_launch = 0; n_bhi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge mclk);
            if (launch_o) n_launch++;
            if (bclk_o || wclk_o) n_bhi++;
        end
        check(n_launch == 0, "R8 gated no strobes", n_launch, 0);
        check(n_bhi == 0, "R8 gated clocks idle", n_bhi, 0);

        // R8: free running with no enables
        set_cfg(1'b0, 2'b00, 1'b0, 1'b0);
        free_run = 1'b1;
        wait_frames(2);
        push_exp(2, 32, "R8 free running");
        wait_sb();

        // R8: receive enable alone
        tick(1);
        free_run = 1'b0; rx_en = 1'b1;
        wait_frames(2);
        push_exp(2, 32, "R8 receive enable");
        wait_sb();

        // R3, R7: divide by 4, 64 bits, bit clock inverted
        set_cfg(1'b1, 2'b01, 1'b1, 1'b0);
        wait_frames(2);
        push_exp(4, 64, "R7 bit clock inverted");
        wait_sb();

        // R4, R7: divide by 2, 128 bits, word clock inverted
        set_cfg(1'b0, 2'b10, 1'b0, 1'b1);
        wait_frames(2);
        push_exp(2, 128, "R7 word clock inverted");
        wait_sb();

        // R4: code 11 is also 128 bits
        set_cfg(1'b1, 2'b11, 1'b0, 1'b0);
        wait_frames(2);
        push_exp(4, 128, "R4 code 11");
        wait_sb();

        // R10: mid-frame ratio change
        set_cfg(1'b0, 2'b00, 1'b0, 1'b0);
        wait_frames(2);
        tick(3);
        push_exp(2, 32, "R10 frame in progress keeps old ratio");
        wait_frames(1);
        tick(5);
        bclk_div_sel = 1'b1;
        frame_sel    = 2'b01;
        wait_sb();
        push_exp(4, 64, "R10 new ratio at next frame");
        wait_sb();

        // R9: global disable with both inversions set
        set_cfg(1'b1, 2'b01, 1'b1, 1'b1);
        glb_en = 1'b0;
        tick(2);
        n_launch = 0; n_bhi = 0; n_whi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge mclk);
            if (launch_o || frame_o) n_launch++;
            if (bclk_o != 1'b1) n_bhi++;
            if (wclk_o != 1'b1) n_whi++;
        end
        check(n_bhi == 0, "R9 bit clock at inverted idle", n_bhi, 0);
        check(n_whi == 0, "R9 word clock at inverted idle", n_whi, 0);
        check(n_launch == 0, "R9 no strobes when disabled", n_launch, 0);

        // R9: restart
        tick(1);
        glb_en = 1'b1;
        wait_frames(2);
        push_exp(4, 64, "R9 restart");
        wait_sb();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule